// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front End

This block is the clocked control side of a pipelined burst static RAM. It also holds a small byte-lane array so that its behaviour can be observed end to end. On every rising clock edge it samples two access-start strobes, a burst-step input, three chip-select inputs, three kinds of write enable, the external address and the write data. From these it decides whether the edge begins a new access, continues the current one or does nothing. It keeps a burst address register whose two low bits count through a group of four locations. It produces per-byte array write strobes and a registered read word with its own drive enable.

The two start strobes differ in two ways. The processor-side strobe (`start_a_n`) only counts while the chip is selected, and the write inputs are ignored on the edge that it starts. The controller-side strobe (`start_b_n`) always checks the chip selects, ends the access when they are inactive, and writes on its own load edge. That makes a single write between bursts possible. The read word appears one clock after the address is taken, and the drive enable is raised only after read cycles, so write data never meets driven outputs.

Top module: `sram_burst_front`

## Requirements
- R1: The device is selected only when `sel_n`=0, `sel2_n`=0 and `sel3`=1 on the same edge. A `start_b_n`=0 edge while it is not selected ends any access, and no array write happens until the next load.
- R2: `start_a_n`=0 has no effect while the device is not selected. An access already in progress continues as if the strobe were high.
- R3: On a selected edge, `start_a_n`=0 or `start_b_n`=0 loads `addr` as the access address for that edge. `start_a_n` wins when both are low.
- R4: On the edge where `start_a_n` loads, `all_wr_n`, `byte_wr_n` and `lane_wr_n` are ignored. No lane strobe fires and the cycle is a read of the loaded address.
- R5: On an edge that does not load, `step_n`=0 moves the address to the next location. Bits [1:0] count up modulo 4 (3 wraps to 0) and the upper bits stay fixed.
- R6: On an edge that does not load, `step_n`=1 keeps the address. A write on that edge goes to the address that was just loaded.
- R7: `start_b_n`=0 in the middle of a burst reloads the address and starts a new access, and a write on that edge goes to the new address.
- R8: All four lanes are written (`lane_we`=4'hF) when `all_wr_n`=0, or when `all_wr_n`=1, `byte_wr_n`=0 and `lane_wr_n`=4'h0.
- R9: With `all_wr_n`=1 and `byte_wr_n`=0, lane n (data bits [8n+7:8n]) is written exactly when `lane_wr_n[n]`=0.
- R10: An access edge with `all_wr_n`=1 and `byte_wr_n`=1 is a read. One clock later `dout` holds the addressed word and `dout_oe`=1. After write edges and idle edges, `dout_oe`=0.
- R11: While reset is asserted and after reset is released, `dout_oe`=0 and no access is active, so `lane_we`=0 until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_a_n | input | 1 | Processor-side access start, active low, gated by selection |
| start_b_n | input | 1 | Controller-side access start, active low, checks selection |
| step_n | input | 1 | Burst step, active low; high holds the address |
| sel_n | input | 1 | Chip select, active low |
| sel2_n | input | 1 | Second chip select, active low |
| sel3 | input | 1 | Third chip select, active high |
| all_wr_n | input | 1 | Whole-word write, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| addr | input | AW | External address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read word |
| dout_oe | output | 1 | Read data drive enable |
| lane_we | output | LANES | Per-lane array write strobes for the current edge |
| cur_addr | output | AW | Address used on the current edge |

## Verification
The assertions assume that reset is low from time zero and that every input is steady around the rising edge. They also assume the address width is at least three bits, so that an upper field exists. The read-data checks are only meaningful for locations that were written before. For that reason the stimulus first fills every location with a known word through whole-word writes, and it changes inputs only on the falling edge. Deselected patterns are applied only after an explicit end of access, except in the one case that checks that a running burst ignores a deselected processor strobe.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  // Kind of work done on one clock edge.
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/sram_sel_ctl.sv
// Access start and selection: decides whether an edge loads, continues
// or is idle, and remembers whether an access is open.
module sram_sel_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_a_n,
  input  logic start_b_n,
  input  logic sel_n,
  input  logic sel2_n,
  input  logic sel3,
  output logic load,
  output logic load_a,
  output logic live
);

  logic selected;
  logic load_b;
  logic drop;
  logic active_q;
  logic active_d;
  logic active_en;

  always_comb begin
    selected  = !sel_n && !sel2_n && sel3;
    load_a    = !start_a_n && selected;
    load_b    = !start_b_n && !load_a && selected;
    drop      = !start_b_n && !load_a && !selected;
    load      = load_a || load_b;
    live      = load || (active_q && !drop);
    active_en = load || drop;
    active_d  = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  // R1: a deselecting controller strobe closes the access
  a_r1_drop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_b_n && (sel_n || sel2_n || !sel3) && start_a_n) |=> !active_q);

  // R2: a processor strobe while deselected leaves the access state alone
  a_r2_ignore_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a_n && start_b_n && (sel_n || sel2_n || !sel3)) |=> $stable(active_q));

  // R3: any load opens an access
  a_r3_load_opens: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active_q);

endmodule

// File: rtl/sram_burst_ctr.sv
// Burst address register: load, step within a four-word group, or hold.
module sram_burst_ctr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] cur_addr
);

  localparam int GRP_W = 2;

  logic [AW-1:0]    cnt_q;
  logic [AW-1:0]    cnt_d;
  logic             cnt_en;
  logic [GRP_W-1:0] low_next;

  always_comb begin
    low_next = cnt_q[GRP_W-1:0] + 2'd1;
    if (load) begin
      cnt_d = addr;
    end else if (!step_n) begin
      cnt_d = {cnt_q[AW-1:GRP_W], low_next};
    end else begin
      cnt_d = cnt_q;
    end
    cnt_en   = load || !step_n;
    cur_addr = cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R3: the loaded address is what the register holds afterwards
  a_r3_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(addr)));

  // R5: stepping keeps the upper field and counts the low field modulo 4
  a_r5_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n) |=> ((cnt_q[AW-1:GRP_W] == $past(cnt_q[AW-1:GRP_W])) &&
                            (cnt_q[GRP_W-1:0] == $past(cnt_q[GRP_W-1:0]) + 2'd1)));

  // R6: a suspended edge holds the address
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> $stable(cnt_q));

endmodule

// File: rtl/sram_wr_dec.sv
// Write-type decode: whole word, per-lane, read, or nothing.
module sram_wr_dec
  import sram_burst_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             ignore_wr,
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lane_we,
  output op_e              op
);

  logic wr_ok;
  logic whole;
  logic partial;

  always_comb begin
    wr_ok   = live && !ignore_wr;
    whole   = wr_ok && !all_wr_n;
    partial = wr_ok && all_wr_n && !byte_wr_n;
    if (!live) begin
      op = OP_NONE;
    end else if (whole || partial) begin
      op = OP_WRITE;
    end else begin
      op = OP_READ;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = whole || (partial && !lane_wr_n[g]);
  end

  // R4: nothing is written on a processor-strobe load edge
  a_r4_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_wr |-> (lane_we == '0 && op == OP_READ));

  // R8: whole-word write request fires every lane
  a_r8_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !ignore_wr && !all_wr_n) |-> (&lane_we));

  // R1: no strobe outside an access
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (lane_we == '0));

endmodule

// File: rtl/sram_lane_array.sv
// Byte-lane storage with a registered read word and its drive enable.
module sram_lane_array
  import sram_burst_pkg::*;
#(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           cur_addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES-1:0]        lane_we,
  input  op_e                     op,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_oe
);

  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * LANE_W;

  logic [DW-1:0] rd_word;
  logic          rd_en;
  logic [DW-1:0] dout_q;
  logic          oe_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) begin
        store[cur_addr] <= din[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word[g*LANE_W +: LANE_W] = store[cur_addr];
  end

  assign rd_en = (op == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (rd_en) begin
      dout_q <= rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
    end else begin
      oe_q <= rd_en;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = oe_q;

  // R10: outputs are never driven right after a write edge
  a_r10_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !dout_oe);

  // R10: a read edge drives the word on the next cycle
  a_r10_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |=> dout_oe);

endmodule

// File: rtl/sram_burst_front.sv
// Top: reset release, selection, burst address, write decode, array.
module sram_burst_front
  import sram_burst_pkg::*;
#(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_a_n,
  input  logic                    start_b_n,
  input  logic                    step_n,
  input  logic                    sel_n,
  input  logic                    sel2_n,
  input  logic                    sel3,
  input  logic                    all_wr_n,
  input  logic                    byte_wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_oe,
  output logic [LANES-1:0]        lane_we,
  output logic [AW-1:0]           cur_addr
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       load;
  logic       load_a;
  logic       live;
  op_e        op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  sram_sel_ctl u_sel (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start_a_n (start_a_n),
    .start_b_n (start_b_n),
    .sel_n     (sel_n),
    .sel2_n    (sel2_n),
    .sel3      (sel3),
    .load      (load),
    .load_a    (load_a),
    .live      (live)
  );

  sram_burst_ctr #(.AW(AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (load),
    .step_n   (step_n),
    .addr     (addr),
    .cur_addr (cur_addr)
  );

  sram_wr_dec #(.LANES(LANES)) u_dec (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .live      (live),
    .ignore_wr (load_a),
    .all_wr_n  (all_wr_n),
    .byte_wr_n (byte_wr_n),
    .lane_wr_n (lane_wr_n),
    .lane_we   (lane_we),
    .op        (op)
  );

  sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cur_addr (cur_addr),
    .din      (din),
    .lane_we  (lane_we),
    .op       (op),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  // R11: drive enable stays low through reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_i_n |=> !dout_oe);

endmodule

// File: tb/sram_burst_front_tb.sv
`timescale 1ns/1ps
module sram_burst_front_tb;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [2:0] ON = 3'b001;  // {sel_n, sel2_n, sel3}

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_a_n, start_b_n, step_n;
  logic          sel_n, sel2_n, sel3;
  logic          all_wr_n, byte_wr_n;
  logic [3:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_oe;
  logic [3:0]    lane_we;
  logic [AW-1:0] cur_addr;

  logic [DW-1:0] model [16];
  logic [3:0]    we_seen;
  logic [AW-1:0] addr_seen;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  sram_burst_front u_dut (
    .clk(clk), .rst_n(rst_n), .start_a_n(start_a_n), .start_b_n(start_b_n),
    .step_n(step_n), .sel_n(sel_n), .sel2_n(sel2_n), .sel3(sel3),
    .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .lane_we(lane_we), .cur_addr(cur_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive on the falling edge, capture the combinational
  // outputs before the rising edge, return just after it.
  task automatic drive(input logic a_n, input logic b_n, input logic st_n,
                       input logic gw, input logic bwe, input logic [3:0] bw,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d,
                       input logic [2:0] sel);
    @(negedge clk);
    start_a_n = a_n; start_b_n = b_n; step_n = st_n;
    all_wr_n = gw; byte_wr_n = bwe; lane_wr_n = bw;
    addr = ad; din = d; {sel_n, sel2_n, sel3} = sel;
    #1;
    we_seen = lane_we;
    addr_seen = cur_addr;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(1, 1, 1, 1, 1, 4'hF, '0, '0, ON);
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a & 4'hC) | ((a + 4'd1) & 4'h3);
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return (32'h0101_0101 * (a + 1)) ^ (32'h9E37_79B9 * (k + 3));
  endfunction

  function automatic logic [3:0] exp_we(input logic gw, input logic bwe, input logic [3:0] bw);
    if (!gw) return 4'hF;
    if (!bwe) return ~bw;
    return 4'h0;
  endfunction

  task automatic mwrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] we);
    for (int n = 0; n < 4; n++)
      if (we[n]) model[a][8*n +: 8] = d[8*n +: 8];
  endtask

  // Controller-strobe read of one location, checked one clock later (R10).
  task automatic rd(input logic [AW-1:0] a, input string req);
    drive(1, 0, 1, 1, 1, 4'hF, a, '0, ON);
    chk(dout_oe === 1'b1, req, {31'd0, dout_oe}, 32'd1);
    chk(dout === model[a], req, dout, model[a]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [AW-1:0] st;
    logic [DW-1:0] d;
    rst_n = 1'b0;
    start_a_n = 1; start_b_n = 1; step_n = 1; all_wr_n = 1; byte_wr_n = 1;
    lane_wr_n = 4'hF; addr = '0; din = '0; {sel_n, sel2_n, sel3} = ON;
    repeat (3) @(posedge clk);
    #1;
    chk(dout_oe === 1'b0, "R11 in reset", {31'd0, dout_oe}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
    chk(dout_oe === 1'b0, "R11 after reset", {31'd0, dout_oe}, 32'd0);
    drive(1, 1, 1, 0, 0, 4'h0, 4'd2, 32'hFFFF_FFFF, ON);
    chk(we_seen === 4'h0, "R11 no access open", {28'd0, we_seen}, 32'd0);

    // Fill every location with whole-word writes (R8, R3)
    for (int i = 0; i < 16; i++) begin
      drive(1, 0, 1, 0, 1, 4'hA, 4'(i), pat(i, 0), ON);
      model[i] = pat(i, 0);
      chk(we_seen === 4'hF, "R8 whole word", {28'd0, we_seen}, 32'hF);
      chk(addr_seen === 4'(i), "R3 load", {28'd0, addr_seen}, i);
      chk(dout_oe === 1'b0, "R10 write no drive", {31'd0, dout_oe}, 32'd0);
    end
    for (int i = 0; i < 16; i++) rd(4'(i), "R10 readback");

    // Burst writes from every start offset, stepping and wrapping (R5)
    for (int g = 0; g < 4; g++) begin
      st = 4'(4 * g + g);
      a = st;
      drive(1, 0, 1, 0, 1, 4'hF, a, pat(a, 1), ON);
      model[a] = pat(a, 1);
      for (int k = 0; k < 3; k++) begin
        a = nxt(a);
        drive(1, 1, 0, 0, 1, 4'hF, ~st, pat(a, 1), ON);
        chk(addr_seen === a, "R5 burst step", {28'd0, addr_seen}, {28'd0, a});
        model[a] = pat(a, 1);
      end
      // Processor-strobe burst read back
      a = st;
      drive(0, 1, 1, 1, 1, 4'hF, a, '0, ON);
      chk(dout === model[a] && dout_oe, "R5 burst read first", dout, model[a]);
      for (int k = 0; k < 3; k++) begin
        a = nxt(a);
        drive(1, 1, 0, 1, 1, 4'hF, ~st, '0, ON);
        chk(dout === model[a], "R5 burst read step", dout, model[a]);
      end
    end

    // Processor-strobe load ignores write inputs, then a held write (R4, R6)
    drive(0, 1, 1, 0, 0, 4'h0, 4'd9, 32'hDEAD_BEEF, ON);
    chk(we_seen === 4'h0, "R4 no strobe", {28'd0, we_seen}, 32'd0);
    chk(dout_oe === 1'b1 && dout === model[9], "R4 read instead", dout, model[9]);
    drive(1, 1, 1, 0, 1, 4'hF, 4'd3, 32'h1234_5678, ON);
    chk(addr_seen === 4'd9, "R6 write to loaded", {28'd0, addr_seen}, 32'd9);
    model[9] = 32'h1234_5678;
    drive(1, 1, 1, 1, 0, 4'h6, 4'd3, 32'hAABB_CCDD, ON);
    chk(addr_seen === 4'd9, "R6 still held", {28'd0, addr_seen}, 32'd9);
    mwrite(4'd9, 32'hAABB_CCDD, 4'h9);
    rd(4'd9, "R4 R6 readback");

    // Every lane-select pattern (R9, R8 for pattern 0)
    for (int m = 0; m < 16; m++) begin
      d = pat(m, 2);
      drive(1, 0, 1, 1, 0, 4'(m), 4'd5, d, ON);
      chk(we_seen === exp_we(1, 0, 4'(m)), "R9 lane strobes", {28'd0, we_seen}, {28'd0, exp_we(1, 0, 4'(m))});
      mwrite(4'd5, d, exp_we(1, 0, 4'(m)));
      rd(4'd5, "R9 lane readback");
    end
    // Byte enable high with lane selects low is a read (R10)
    drive(1, 0, 1, 1, 1, 4'h0, 4'd5, 32'h0BAD_0BAD, ON);
    chk(we_seen === 4'h0 && dout === model[5] && dout_oe, "R10 read with lanes low", dout, model[5]);

    // Every deselecting combination (R1, R2)
    for (int c = 0; c < 8; c++) begin
      if (c == 1) continue;
      drive(1, 0, 1, 0, 1, 4'hF, 4'd3, 32'h5555_0000 + c, 3'(c));
      chk(we_seen === 4'h0, "R1 deselect no write", {28'd0, we_seen}, 32'd0);
      chk(dout_oe === 1'b0, "R1 deselect no drive", {31'd0, dout_oe}, 32'd0);
      drive(0, 1, 1, 0, 1, 4'hF, 4'd3, 32'h6666_0000 + c, 3'(c));
      chk(we_seen === 4'h0, "R2 ignored strobe", {28'd0, we_seen}, 32'd0);
      drive(1, 1, 1, 0, 1, 4'hF, 4'd3, 32'h7777_0000 + c, ON);
      chk(we_seen === 4'h0, "R1 access closed", {28'd0, we_seen}, 32'd0);
      rd(4'd3, "R1 R2 memory unchanged");
      // Running burst ignores a deselected processor strobe (R2)
      drive(1, 0, 1, 1, 1, 4'hF, 4'd12, '0, ON);
      drive(0, 1, 0, 1, 1, 4'hF, 4'd7, '0, 3'(c));
      chk(dout === model[13] && dout_oe, "R2 burst continues", dout, model[13]);
    end

    // Controller strobe mid-burst places a single write (R7)
    drive(0, 1, 1, 1, 1, 4'hF, 4'd8, '0, ON);
    drive(1, 1, 0, 1, 1, 4'hF, 4'd8, '0, ON);
    chk(dout === model[9], "R7 burst before", dout, model[9]);
    drive(1, 0, 1, 0, 1, 4'hF, 4'd2, 32'hC0DE_0002, ON);
    chk(addr_seen === 4'd2 && we_seen === 4'hF, "R7 reload write", {28'd0, addr_seen}, 32'd2);
    model[2] = 32'hC0DE_0002;
    drive(1, 1, 0, 0, 1, 4'hF, 4'd9, 32'hC0DE_0003, ON);
    model[3] = 32'hC0DE_0003;
    drive(1, 1, 0, 0, 1, 4'hF, 4'd9, 32'hC0DE_0000, ON);
    chk(addr_seen === 4'd0, "R7 R5 wrap after reload", {28'd0, addr_seen}, 32'd0);
    model[0] = 32'hC0DE_0000;
    rd(4'd2, "R7 readback");
    rd(4'd3, "R7 readback");
    rd(4'd0, "R7 readback");
    rd(4'd1, "R7 neighbour unchanged");

    // Suspended read burst keeps returning the same word (R6)
    drive(1, 0, 1, 1, 1, 4'hF, 4'd14, '0, ON);
    for (int k = 0; k < 3; k++) begin
      drive(1, 1, 1, 1, 1, 4'hF, 4'd1, '0, ON);
      chk(dout === model[14] && addr_seen === 4'd14, "R6 suspend read", dout, model[14]);
    end
    idle();
    chk(dout_oe === 1'b1, "R10 open access reads", {31'd0, dout_oe}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule